// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side DMA engine of an Ethernet MAC. It takes the received frame as a byte stream and scatters it into fixed 128-byte buffers in system memory. Each buffer is found through a two-word descriptor: an address word followed by a status word. The descriptors sit back to back in a ring that starts at a queue base address. For every buffer it fills, the block writes the status word and then hands the descriptor to software by setting the ownership bit in the address word. The ring closes at the descriptor whose wrap bit is set.

Ownership is the only handshake with software. A clear ownership bit means the buffer is free for hardware. A set bit means software has not yet consumed the buffer. When a frame needs a buffer that software still holds, the rest of that frame is thrown away and a buffer-not-available pulse is raised. When a frame is fully written back, a completion pulse serves as the receive interrupt. An optional mode strips the 4-byte frame check sequence before storage.

The memory port is a single 32-bit port. Writes are taken in the cycle of the request, and read data comes back one cycle after the request. While the block fetches or writes back a descriptor, it stalls the byte stream with `in_ready`.

The controller is a state machine with seven named states:

- **IDLE**: the receiver is off, and bytes are accepted and dropped.
- **FETCH**: the address word at the ring position is read.
- **CHECK**: the read word is examined. If it is free, the buffer is latched and the next state is FILL. If it is owned and a frame is pending or in progress, the next state is DROP. If it is owned and no frame is pending, the next state is FETCH again.
- **FILL**: bytes are packed into words and written. The state moves to STAT at the end of the frame or when the buffer is full.
- **STAT**: the status word is written.
- **OWN**: the address word is rewritten with ownership set. The next state is FETCH.
- **DROP**: bytes are consumed until the end of the frame, then the next state is FETCH.

Clearing `rx_enable` forces IDLE from any state.

Top module: `rxdr_ring_writer`

## Requirements
- R1: Descriptors are used in order from `queue_base`, 8 bytes apart; after a descriptor whose address word has bit 1 (wrap) set, the next one used is at `queue_base`.
- R2: Frame bytes are stored at the buffer address taken from address-word bits 31:2, byte k of a buffer in bits 8*(k mod 4)+7:8*(k mod 4) of word k/4, 128 bytes per buffer; a longer frame continues in the following descriptors.
- R3: The status word (second word of the descriptor) has bit 14 set only in the first buffer of a frame, bit 15 set only in the last, and bits 10:0 equal to the stored frame length in the last buffer and zero otherwise; all other bits are zero.
- R4: After a buffer is filled, its status word is written, and in the very next cycle its address word is rewritten with bit 0 (ownership) set and the address and wrap bits unchanged.
- R5: With `discard_fcs` high, the last 4 bytes of each frame (frames of at least 5 bytes) are neither stored nor counted in the length.
- R6: `frame_done` pulses for one cycle exactly once per stored frame, in the cycle after the ownership write of its final descriptor.
- R7: If the descriptor for a new frame has ownership set, nothing is written, the frame is dropped, `buf_unavail` pulses once, and the next frame goes to that same descriptor once software clears its ownership.
- R8: If ownership is found set in the middle of a frame, the buffers already written keep start-of-frame without end-of-frame, the remainder is dropped, `buf_unavail` pulses, no `frame_done` is raised, and the next frame starts at the descriptor that was owned.
- R9: With `rx_enable` low, input bytes are accepted and discarded without memory writes; after re-enabling, the ring position restarts at `queue_base`.
- R10: After reset with the receiver disabled there is no memory request, no pulse and `in_ready` is high; every memory access is word aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; low returns the ring to its base |
| discard_fcs | input | 1 | Strip the trailing 4 check bytes of each frame |
| queue_base | input | 32 | Byte address of the first descriptor (8-byte aligned) |
| in_valid | input | 1 | Received byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| frame_done | output | 1 | One-cycle pulse per completed frame |
| buf_unavail | output | 1 | One-cycle pulse when a needed buffer is still owned by software |

## Verification
The bench sweeps frame lengths around every word and buffer boundary: 1 to 9 bytes, 126 to 130, 255 to 257, 384, 385 and 512. These lengths separate partial-word packing, a frame ending exactly on a buffer edge, and frames chained over two, three and four buffers. Because the ring has only four descriptors, the sweep also wraps repeatedly. The same boundaries are repeated with check-byte stripping, which shows whether the held-back bytes shift the buffer split. Descriptors are pre-marked as owned to tell a drop at the start of a frame from one in the middle. A frame sent while the receiver is disabled, followed by a disable/enable toggle, shows that input is ignored and that the ring restarts at its base.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_FILL,
        S_STAT,
        S_OWN,
        S_DROP
    } rx_state_e;

    // descriptor layout that software decodes
    localparam int OWN_BIT    = 0;
    localparam int WRAP_BIT   = 1;
    localparam int SOF_BIT    = 14;
    localparam int EOF_BIT    = 15;
    localparam int DESC_BYTES = 8;
    localparam int STAT_OFS   = 4;

endpackage

// File: rtl/rxdr_fcs_strip.sv
// Holds back the trailing HOLD bytes of each frame when enabled.
module rxdr_fcs_strip #(
    parameter int HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       enable,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int CW = $clog2(HOLD + 1);

    logic [7:0]    hold_q [HOLD];
    logic [CW-1:0] cnt_q;
    logic          full;
    logic          filling;
    logic          take;

    assign full      = (cnt_q == CW'(HOLD));
    assign filling   = enable && !full;
    assign out_valid = in_valid && (!enable || full);
    assign out_data  = enable ? hold_q[0] : in_data;
    assign out_last  = in_last;
    assign in_ready  = filling ? 1'b1 : out_ready;
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (flush) begin
            cnt_q <= '0;
        end else if (take) begin
            if (in_last)      cnt_q <= '0;
            else if (filling) cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < HOLD; i++) begin : g_lane
        logic [7:0] shift_in;
        if (i == HOLD - 1) begin : g_tail
            assign shift_in = in_data;
        end else begin : g_body
            assign shift_in = hold_q[i+1];
        end
        always_ff @(posedge clk) begin
            if (take && enable) begin
                if (full)                   hold_q[i] <= shift_in;
                else if (cnt_q == CW'(i))   hold_q[i] <= in_data;
            end
        end
    end

endmodule

// File: rtl/rxdr_word_pack.sv
// Gathers bytes into a memory word; lanes above the current one read as zero.
module rxdr_word_pack #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               take,
    input  logic [LW-1:0]      lane,
    input  logic [7:0]         in_byte,
    output logic [8*LANES-1:0] word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (take && lane == LW'(i)) byte_q <= in_byte;
        end
        assign word[8*i +: 8] = (lane == LW'(i)) ? in_byte :
                                (LW'(i) < lane)  ? byte_q  : 8'h00;
    end
endmodule

// File: rtl/rxdr_ring_ptr.sv
// Current descriptor position within the ring.
module rxdr_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (load)    ptr <= base;
        else if (advance) ptr <= wrap ? base : ptr + AW'(STEP);
    end
endmodule

// File: rtl/rxdr_ring_writer.sv
module rxdr_ring_writer
    import rxdr_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int LEN_W     = 11,
    parameter int FCS_BYTES = 4,
    parameter int AW        = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          discard_fcs,
    input  logic [AW-1:0] queue_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          frame_done,
    output logic          buf_unavail
);
    localparam int DW     = 32;
    localparam int LANES  = DW / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(BUF_BYTES);

    rx_state_e state_q, state_d;

    logic             s_valid, s_last, s_ready;
    logic [7:0]       s_data;
    logic [AW-3:0]    buf_base_q;
    logic             wrap_q, sof_q, eof_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q, bna_q;
    logic [AW-1:0]    ptr;
    logic [DW-1:0]    pack_word;
    logic [DW-1:0]    status_word;
    logic             owned, at_end, byte_take, word_flush, drop_now;

    rxdr_fcs_strip #(.HOLD(FCS_BYTES)) u_strip (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!rx_enable),
        .enable   (discard_fcs),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .out_valid(s_valid),
        .out_data (s_data),
        .out_last (s_last),
        .out_ready(s_ready)
    );

    rxdr_word_pack #(.LANES(LANES)) u_pack (
        .clk    (clk),
        .take   (byte_take),
        .lane   (cnt_q[LANE_W-1:0]),
        .in_byte(s_data),
        .word   (pack_word)
    );

    rxdr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (!rx_enable),
        .advance(state_q == S_OWN),
        .wrap   (wrap_q),
        .base   (queue_base),
        .ptr    (ptr)
    );

    assign owned      = mem_rdata[OWN_BIT];
    assign at_end     = (cnt_q == CNT_W'(BUF_BYTES - 1));
    assign byte_take  = (state_q == S_FILL) && s_valid;
    assign word_flush = byte_take && (cnt_q[LANE_W-1:0] == LANE_W'(LANES - 1) || s_last || at_end);
    assign drop_now   = owned && (s_valid || !sof_q);

    always_comb begin
        status_word          = '0;
        status_word[EOF_BIT] = eof_q;
        status_word[SOF_BIT] = sof_q;
        if (eof_q) status_word[LEN_W-1:0] = len_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (rx_enable) state_d = S_FETCH;
            S_FETCH: state_d = S_CHECK;
            S_CHECK: begin
                if (!owned)        state_d = S_FILL;
                else if (drop_now) state_d = S_DROP;
                else               state_d = S_FETCH;
            end
            S_FILL:  if (byte_take && (s_last || at_end)) state_d = S_STAT;
            S_STAT:  state_d = S_OWN;
            S_OWN:   state_d = S_FETCH;
            S_DROP:  if (s_valid && s_last) state_d = S_FETCH;
            default: state_d = S_IDLE;
        endcase
        if (!rx_enable) state_d = S_IDLE;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        s_ready   = 1'b0;
        unique case (state_q)
            S_IDLE:  s_ready = 1'b1;
            S_FETCH: mem_req = 1'b1;
            S_CHECK: ;
            S_FILL: begin
                s_ready   = 1'b1;
                mem_req   = word_flush;
                mem_we    = word_flush;
                mem_addr  = {buf_base_q, 2'b00} + AW'({cnt_q[CNT_W-1:LANE_W], {LANE_W{1'b0}}});
                mem_wdata = pack_word;
            end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + AW'(STAT_OFS);
                mem_wdata = status_word;
            end
            S_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {buf_base_q, wrap_q, 1'b1};
            end
            S_DROP:  s_ready = 1'b1;
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_base_q <= '0;
            wrap_q     <= 1'b0;
            cnt_q      <= '0;
            len_q      <= '0;
            sof_q      <= 1'b1;
            eof_q      <= 1'b0;
            done_q     <= 1'b0;
            bna_q      <= 1'b0;
        end else begin
            done_q <= rx_enable && (state_q == S_OWN) && eof_q;
            bna_q  <= rx_enable && (state_q == S_CHECK) && drop_now;
            if (!rx_enable) begin
                sof_q <= 1'b1;
                len_q <= '0;
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    S_CHECK: if (!owned) begin
                        buf_base_q <= mem_rdata[AW-1:2];
                        wrap_q     <= mem_rdata[WRAP_BIT];
                        cnt_q      <= '0;
                        eof_q      <= 1'b0;
                    end
                    S_FILL: if (byte_take) begin
                        cnt_q <= cnt_q + 1'b1;
                        len_q <= len_q + 1'b1;
                        eof_q <= s_last;
                    end
                    S_OWN: begin
                        sof_q <= eof_q;
                        if (eof_q) len_q <= '0;
                    end
                    S_DROP: if (s_valid && s_last) begin
                        sof_q <= 1'b1;
                        len_q <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frame_done  = done_q;
    assign buf_unavail = bna_q;

endmodule

// File: rtl/rxdr_ring_writer_chk.sv
module rxdr_ring_writer_chk
    import rxdr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input rx_state_e   state,
    input logic [31:0] queue_base,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        frame_done,
    input logic        buf_unavail
);
    assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_status_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OWN) |-> (mem_req && mem_we && mem_wdata[OWN_BIT]
                              && $past(mem_req && mem_we)
                              && $past(mem_addr) == mem_addr + 32'd4));

    assert_done_after_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(state == S_OWN));

    assert_len_on_eof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STAT && mem_req && mem_we) |->
            (mem_wdata[EOF_BIT] ? (mem_wdata[10:0] != 11'd0) : (mem_wdata[10:0] == 11'd0)));

    assert_no_done_with_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && buf_unavail));

    assert_restart_at_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && $past(state == S_IDLE)) |-> mem_addr == queue_base);

    assert_ring_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && $past(state == S_OWN)) |->
            mem_addr == ($past(mem_wdata[WRAP_BIT]) ? queue_base : $past(mem_addr) + 32'd8));
endmodule

bind rxdr_ring_writer rxdr_ring_writer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state_q),
    .queue_base (queue_base),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .frame_done (frame_done),
    .buf_unavail(buf_unavail)
);

// File: tb/rxdr_ring_writer_tb.sv
module rxdr_ring_writer_tb;
    localparam int NDESC = 4;
    localparam int BUF0  = 32'h100;
    localparam int BSZ   = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        discard_fcs = 1'b0;
    logic [31:0] queue_base = 32'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready, mem_req, mem_we, frame_done, buf_unavail;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;

    logic [31:0] mem [256];
    logic        sw_we = 1'b0;
    logic [7:0]  sw_addr = 8'h0;
    logic [31:0] sw_data = 32'h0;
    logic        mem_clr = 1'b0;

    int checks = 0, fails = 0;
    int done_cnt = 0, bna_cnt = 0, wr_cnt = 0;
    int exp_ptr = 0;
    int fid = 0;

    always #10 clk = ~clk;

    rxdr_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .discard_fcs(discard_fcs),
        .queue_base(queue_base), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .frame_done(frame_done),
        .buf_unavail(buf_unavail)
    );

    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
        end else begin
            if (sw_we) mem[sw_addr] <= sw_data;
            if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (rst_n && frame_done)          done_cnt <= done_cnt + 1;
        if (rst_n && buf_unavail)         bna_cnt  <= bna_cnt + 1;
        if (rst_n && mem_req && mem_we)   wr_cnt   <= wr_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int f, input int i);
        return 8'((f * 13 + i * 7 + 1) & 255);
    endfunction

    function automatic logic [31:0] desc_word(input int k, input bit own);
        return 32'(BUF0 + BSZ * k) | ((k == NDESC - 1) ? 32'h2 : 32'h0) | (own ? 32'h1 : 32'h0);
    endfunction

    task automatic sw_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 8'(idx); sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic send_frame(input int f, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb(f, i); in_last = (i == n - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // checks stored buffers of a frame starting at exp_ptr, then releases them
    task automatic verify(input int f, input int len, input bit complete, input int nbuf);
        for (int b = 0; b < nbuf; b++) begin
            int k = (exp_ptr + b) % NDESC;
            int nbytes = (len - BSZ * b > BSZ) ? BSZ : len - BSZ * b;
            logic [31:0] st;
            bit lastb = complete && (b == nbuf - 1);
            st = (b == 0 ? 32'h4000 : 32'h0) | (lastb ? (32'h8000 | 32'(len)) : 32'h0);
            chk("R4 ownership word", mem[2*k], desc_word(k, 1'b1));
            chk("R3 status word", mem[2*k+1], st);
            for (int j = 0; j < nbytes; j++) begin
                logic [31:0] w = mem[(BUF0 + BSZ * k) / 4 + j / 4];
                chk("R2 stored byte", 32'(w[8*(j%4) +: 8]), 32'(fb(f, BSZ * b + j)));
            end
        end
        for (int b = 0; b < nbuf; b++) sw_write(2 * ((exp_ptr + b) % NDESC), desc_word((exp_ptr + b) % NDESC, 1'b0));
        exp_ptr = (exp_ptr + nbuf) % NDESC;
    endtask

    task automatic run_frame(input int n, input bit disc);
        int len = disc ? n - 4 : n;
        int d0 = done_cnt;
        discard_fcs = disc;
        fid++;
        send_frame(fid, n);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(disc ? "R5 frame done" : "R6 frame done", 32'(done_cnt - d0), 32'd1);
        verify(fid, len, 1'b1, (len + BSZ - 1) / BSZ);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w0, d0, b0;
        mem_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mem_clr = 1'b0;
        chk("R10 no request in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle request", 32'(mem_req), 32'd0);
        chk("R10 idle done", 32'(frame_done), 32'd0);
        chk("R10 idle unavail", 32'(buf_unavail), 32'd0);
        chk("R10 idle ready", 32'(in_ready), 32'd1);
        for (int k = 0; k < NDESC; k++) sw_write(2 * k, desc_word(k, 1'b0));

        // R9: bytes while disabled are swallowed
        w0 = wr_cnt;
        send_frame(99, 10);
        repeat (4) @(posedge clk);
        chk("R9 no writes while disabled", 32'(wr_cnt - w0), 32'd0);
        chk("R9 no done while disabled", 32'(done_cnt), 32'd0);

        rx_enable = 1'b1;
        repeat (4) @(posedge clk);

        // R1/R2/R3/R6: length sweep across word and buffer edges, ring wraps
        for (int n = 1; n <= 9; n++)     run_frame(n, 1'b0);
        for (int n = 126; n <= 130; n++) run_frame(n, 1'b0);
        for (int n = 255; n <= 257; n++) run_frame(n, 1'b0);
        run_frame(384, 1'b0);
        run_frame(385, 1'b0);
        run_frame(512, 1'b0);

        // R5: check bytes stripped
        for (int n = 5; n <= 9; n++)     run_frame(n, 1'b1);
        for (int n = 131; n <= 133; n++) run_frame(n, 1'b1);
        run_frame(260, 1'b1);

        // R7: next descriptor owned at frame start
        sw_write(2 * ((exp_ptr + 1) % NDESC), desc_word((exp_ptr + 1) % NDESC, 1'b1));
        run_frame(20, 1'b0);
        w0 = wr_cnt; d0 = done_cnt; b0 = bna_cnt;
        fid++;
        send_frame(fid, 20);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R7 unavailable pulse", 32'(bna_cnt - b0), 32'd1);
        chk("R7 no done", 32'(done_cnt - d0), 32'd0);
        chk("R7 no writes", 32'(wr_cnt - w0), 32'd0);
        chk("R7 descriptor untouched", mem[2 * exp_ptr], desc_word(exp_ptr, 1'b1));
        sw_write(2 * exp_ptr, desc_word(exp_ptr, 1'b0));
        sw_write(2 * ((exp_ptr + 2) % NDESC), desc_word((exp_ptr + 2) % NDESC, 1'b1));
        run_frame(30, 1'b0);

        // R8: ownership hit in the middle of a frame
        d0 = done_cnt; b0 = bna_cnt;
        fid++;
        send_frame(fid, 200);
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk("R8 unavailable pulse", 32'(bna_cnt - b0), 32'd1);
        chk("R8 no done", 32'(done_cnt - d0), 32'd0);
        verify(fid, 200, 1'b0, 1);
        sw_write(2 * exp_ptr, desc_word(exp_ptr, 1'b0));
        run_frame(40, 1'b0);
        chk("R8 ring position moved", 32'(exp_ptr != 0), 32'd1);

        // R9: disable/enable restarts at the base
        @(negedge clk);
        rx_enable = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rx_enable = 1'b1;
        exp_ptr = 0;
        run_frame(40, 1'b0);
        chk("R9 restart at base", 32'(exp_ptr), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule